// File: doc/BRIEF.md
# Instruction Trace View Filter

The filter sits beside a processor's retirement stage and decides, for each retired instruction, whether that instruction belongs to the region being traced. Every instruction arrives with its address, the exception level it ran at, its security state and a valid strobe. One cycle later the block presents a trace-enable flag for that instruction.

The decision combines three mechanisms. First, a bank of address comparators. Pairs of comparators can bound inclusive address ranges that are selected as include regions. Single comparators can act as exact-address start or stop points. Second, a per-comparator exclusion mask that suppresses matches at chosen exception levels and security states. Third, one start/stop state bit that start points set and stop points clear. Software can read this bit through a dedicated output and can write it to resume a region that was left in the started state.

All settings are loaded through a simple write port: an enable, a 6-bit register address and 64 bits of data. Each register takes the whole write.

Top module: `trace_view_filter`

## Requirements
- R1: After reset, `trace_valid`, `trace_en` and `ss_status` are 0 and every register is 0. The enabling event is therefore off and no instruction is traced until software writes the control register.
- R2: The register addresses are as follows. Address i (0..NCMP-1) holds comparator i's 64-bit value. Address 16+i holds comparator i's access word. Address 32 is the view control word. Address 33 is the include word. Address 34 is the start/stop word. A write takes effect for instructions presented on the following cycle.
- R3: Range pair k consists of comparator 2k as the low bound and comparator 2k+1 as the high bound. It matches when low <= address <= high, compared as unsigned 64-bit values.
- R4: Bit k of the include word selects range pair k as an include region. When the include word is zero, every address counts as in range.
- R5: For an instruction presented with `instr_valid` high, `trace_valid` is 1 on the next cycle. On that same cycle, `trace_en` is the AND of three conditions: the enabling event, the in-range condition, and the start/stop state that was held when the instruction was presented.
- R6: Bit 0 of the view control word selects the always-true enabling event. While this bit is 0, `trace_en` stays 0.
- R7: Writing the view control word loads its bit 9 into the start/stop state, where 1 means started. `ss_status` always shows this state.
- R8: In the start/stop word, bit i marks comparator i as a start point and bit 16+i marks it as a stop point. A point hits on an exact address match, and any comparator index, odd or even, may be used.
- R9: When a start point and a stop point both hit on the same instruction, the state becomes stopped.
- R10: A state change caused by an instruction applies from the next instruction onward. The instruction that hits a point is judged with the old state.
- R11: Bits 11:8 of an access word exclude secure EL0..EL3, and bits 15:12 exclude non-secure EL0..EL3. A set bit blocks that comparator from matching at that level. A range pair uses the mask of its even comparator.
- R12: When no start or stop point is programmed, the start/stop state keeps the last value written to it.
- R13: When a view-control write and a valid instruction occur on the same cycle, the written status bit takes priority over any start or stop hit from that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 64 | Register write data |
| instr_valid | input | 1 | A retired instruction is presented |
| instr_addr | input | 64 | Instruction address |
| instr_el | input | 2 | Exception level 0..3 |
| instr_ns | input | 1 | 1 = non-secure state |
| trace_valid | output | 1 | Registered copy of the instruction strobe |
| trace_en | output | 1 | Instruction lies inside the traced view |
| ss_status | output | 1 | Current start/stop state (1 = started) |

## Verification
Directed sequences test the points where an off-by-one or an ordering error would show. Range addresses are placed just below, on, and just above each bound, including the all-ones address against a full-span range. Start and stop points are placed on odd and even comparators, and the two are made to collide on one instruction. A view-control write is made to coincide with an instruction that hits a point. Exclusion masks are tried at several level and security combinations, which separates a mask applied to the wrong comparator or the wrong bank. Random configurations over a small address window then combine ranges, masks and start/stop points, so that many hits and misses occur. Each outcome is compared with a bench model of the state bit and the range decision.

// File: rtl/tvf_pkg.sv
// Package for the trace view filter.
// Holds the register address map and the access-mask bit layout shared by the
// register file and the comparator bank. Assumes at most 8 range pairs.
package tvf_pkg;
    localparam int unsigned WR_ADDR_W = 6;

    localparam logic [WR_ADDR_W-1:0] RA_VAL_BASE = 6'd0;
    localparam logic [WR_ADDR_W-1:0] RA_ACC_BASE = 6'd16;
    localparam logic [WR_ADDR_W-1:0] RA_VIEW     = 6'd32;
    localparam logic [WR_ADDR_W-1:0] RA_INCL     = 6'd33;
    localparam logic [WR_ADDR_W-1:0] RA_SS       = 6'd34;

    // Bit positions inside the written words.
    localparam int unsigned VIEW_EVENT_BIT  = 0;
    localparam int unsigned VIEW_STATUS_BIT = 9;
    localparam int unsigned SS_STOP_SHIFT   = 16;
    localparam int unsigned ACC_LO          = 8;
    localparam int unsigned ACC_HI          = 15;

    // Stored mask byte: bits 3:0 secure EL0..3, bits 7:4 non-secure EL0..3.
    typedef logic [7:0] acc_mask_t;
endpackage

// File: rtl/tvf_regs.sv
// Register file of the trace view filter.
// Decodes the write port into comparator values, exclusion masks, the event
// enable, the include word and the start/stop point masks. The status bit is
// not stored here: a view-control write is forwarded as a load pulse.
// Assumes NCMP <= 16 so that all comparator addresses fit their windows.
module tvf_regs
    import tvf_pkg::*;
#(
    parameter int unsigned AW    = 64,
    parameter int unsigned NPAIR = 4,
    localparam int unsigned NCMP = 2 * NPAIR
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [WR_ADDR_W-1:0]           wr_addr,
    input  logic [AW-1:0]                  wr_data,
    output logic [NCMP-1:0][AW-1:0]        cmp_val,
    output acc_mask_t [NCMP-1:0]           cmp_acc,
    output logic                           ev_on,
    output logic [NPAIR-1:0]               incl,
    output logic [NCMP-1:0]                ss_start,
    output logic [NCMP-1:0]                ss_stop,
    output logic                           st_wr,
    output logic                           st_val
);

    // Load pulse for the start/stop state on a view-control write.
    always_comb begin
        st_wr  = wr_en && (wr_addr == RA_VIEW);
        st_val = wr_data[VIEW_STATUS_BIT];
    end

    // Capture writes into the comparator, mask and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_val  <= '0;
            cmp_acc  <= '0;
            ev_on    <= 1'b0;
            incl     <= '0;
            ss_start <= '0;
            ss_stop  <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NCMP; i++) begin
                if (wr_addr == RA_VAL_BASE + WR_ADDR_W'(i))
                    cmp_val[i] <= wr_data;
                if (wr_addr == RA_ACC_BASE + WR_ADDR_W'(i))
                    cmp_acc[i] <= wr_data[ACC_HI:ACC_LO];
            end
            if (wr_addr == RA_VIEW)
                ev_on <= wr_data[VIEW_EVENT_BIT];
            if (wr_addr == RA_INCL)
                incl <= wr_data[NPAIR-1:0];
            if (wr_addr == RA_SS) begin
                ss_start <= wr_data[NCMP-1:0];
                ss_stop  <= wr_data[SS_STOP_SHIFT+NCMP-1:SS_STOP_SHIFT];
            end
        end
    end

endmodule

// File: rtl/tvf_cmp_bank.sv
// Comparator bank of the trace view filter.
// Produces, for the presented instruction, one exact-match flag per comparator
// and one inclusive range-match flag per pair, each qualified by the level mask.
// Purely combinational; assumes the caller gates with the valid strobe.
module tvf_cmp_bank
    import tvf_pkg::*;
#(
    parameter int unsigned AW    = 64,
    parameter int unsigned NPAIR = 4,
    localparam int unsigned NCMP = 2 * NPAIR
) (
    input  logic [NCMP-1:0][AW-1:0] cmp_val,
    input  acc_mask_t [NCMP-1:0]    cmp_acc,
    input  logic [AW-1:0]           addr,
    input  logic [1:0]              el,
    input  logic                    ns,
    output logic [NCMP-1:0]         pt_hit,
    output logic [NPAIR-1:0]        rng_hit
);

    logic [2:0]      lvl_idx;
    logic [NCMP-1:0] lvl_ok;

    // Select the mask bit for the current security state and level.
    always_comb lvl_idx = {ns, el};

    for (genvar i = 0; i < NCMP; i++) begin : g_pt
        // Exact-address match of one comparator, blocked by its level mask.
        always_comb begin
            lvl_ok[i] = !cmp_acc[i][lvl_idx];
            pt_hit[i] = lvl_ok[i] && (addr == cmp_val[i]);
        end
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_rng
        // Inclusive unsigned range test of pair k using the even comparator's mask.
        always_comb
            rng_hit[k] = lvl_ok[2*k] && (addr >= cmp_val[2*k]) && (addr <= cmp_val[2*k+1]);
    end

endmodule

// File: rtl/tvf_ss_state.sv
// Start/stop state bit of the trace view filter.
// Set by a start hit, cleared by a stop hit (stop wins), loaded directly by a
// software write which overrides both. Updates land at the clock edge, so the
// instruction causing a change still sees the old value.
module tvf_ss_state (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic start_hit,
    input  logic stop_hit,
    input  logic st_wr,
    input  logic st_val,
    output logic started
);

    // Update the state bit by priority: write, stop, start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            started <= 1'b0;
        else if (st_wr)
            started <= st_val;
        else if (instr_valid && stop_hit)
            started <= 1'b0;
        else if (instr_valid && start_hit)
            started <= 1'b1;
    end

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && stop_hit && !st_wr |=> !started); // R9
    AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && start_hit && !stop_hit && !st_wr |=> started); // R8
    AST_WRITE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> started == $past(st_val)); // R13
    AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid && !st_wr |=> $stable(started)); // R12

endmodule

// File: rtl/trace_view_filter.sv
// Top of the instruction trace view filter.
// Combines the event enable, the include ranges and the start/stop state into a
// per-instruction trace-enable flag, registered one cycle after the strobe.
// Assumes NPAIR <= 8 and a 64-bit write port wide enough for every word.
module trace_view_filter
    import tvf_pkg::*;
#(
    parameter int unsigned AW    = 64,
    parameter int unsigned NPAIR = 4,
    localparam int unsigned NCMP = 2 * NPAIR
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WR_ADDR_W-1:0] wr_addr,
    input  logic [AW-1:0]        wr_data,
    input  logic                 instr_valid,
    input  logic [AW-1:0]        instr_addr,
    input  logic [1:0]           instr_el,
    input  logic                 instr_ns,
    output logic                 trace_valid,
    output logic                 trace_en,
    output logic                 ss_status
);

    logic [NCMP-1:0][AW-1:0] cmp_val;
    acc_mask_t [NCMP-1:0]    cmp_acc;
    logic                    ev_on;
    logic [NPAIR-1:0]        incl;
    logic [NCMP-1:0]         ss_start;
    logic [NCMP-1:0]         ss_stop;
    logic                    st_wr;
    logic                    st_val;
    logic [NCMP-1:0]         pt_hit;
    logic [NPAIR-1:0]        rng_hit;
    logic                    start_hit;
    logic                    stop_hit;
    logic                    in_view;
    logic                    en_now;

    tvf_regs #(.AW(AW), .NPAIR(NPAIR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmp_val  (cmp_val),
        .cmp_acc  (cmp_acc),
        .ev_on    (ev_on),
        .incl     (incl),
        .ss_start (ss_start),
        .ss_stop  (ss_stop),
        .st_wr    (st_wr),
        .st_val   (st_val)
    );

    tvf_cmp_bank #(.AW(AW), .NPAIR(NPAIR)) u_cmp (
        .cmp_val (cmp_val),
        .cmp_acc (cmp_acc),
        .addr    (instr_addr),
        .el      (instr_el),
        .ns      (instr_ns),
        .pt_hit  (pt_hit),
        .rng_hit (rng_hit)
    );

    // Reduce comparator hits into start/stop events and the include decision.
    always_comb begin
        start_hit = |(pt_hit & ss_start);
        stop_hit  = |(pt_hit & ss_stop);
        in_view   = (incl == '0) || (|(rng_hit & incl));
        en_now    = ev_on && in_view && ss_status;
    end

    tvf_ss_state u_ss (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .start_hit   (start_hit),
        .stop_hit    (stop_hit),
        .st_wr       (st_wr),
        .st_val      (st_val),
        .started     (ss_status)
    );

    // Register the per-instruction decision and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_valid <= 1'b0;
            trace_en    <= 1'b0;
        end else begin
            trace_valid <= instr_valid;
            trace_en    <= instr_valid && en_now;
        end
    end

    AST_EN_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        trace_en |-> trace_valid); // R5
    AST_EVENT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && !ev_on |=> !trace_en); // R6
    AST_STOPPED_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && !ss_status |=> !trace_en); // R10

endmodule

// File: tb/trace_view_filter_bench.sv
module trace_view_filter_bench;
    localparam int NP = 4;
    localparam int NC = 2 * NP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        instr_valid = 1'b0;
    logic [63:0] instr_addr = '0;
    logic [1:0]  instr_el = '0;
    logic        instr_ns = 1'b0;
    logic        trace_valid, trace_en, ss_status;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // Bench model of the programmed state
    logic [63:0] mval [NC];
    logic [7:0]  macc [NC];
    bit          mev;
    bit [NP-1:0] mincl;
    bit [NC-1:0] mstart, mstop;
    bit          mstat;

    trace_view_filter #(.AW(64), .NPAIR(NP)) u_trace_view_filter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .instr_valid(instr_valid), .instr_addr(instr_addr), .instr_el(instr_el),
        .instr_ns(instr_ns), .trace_valid(trace_valid), .trace_en(trace_en),
        .ss_status(ss_status)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit lvl_ok(int i, bit [1:0] el, bit ns);
        return !macc[i][int'(ns) * 4 + int'(el)];
    endfunction

    function automatic bit exp_en(logic [63:0] a, bit [1:0] el, bit ns);
        bit inr = (mincl == 0);
        for (int k = 0; k < NP; k++)
            if (mincl[k] && lvl_ok(2*k, el, ns) && mval[2*k] <= a && a <= mval[2*k+1])
                inr = 1;
        return mev && inr && mstat;
    endfunction

    function automatic bit any_hit(bit [NC-1:0] sel, logic [63:0] a, bit [1:0] el, bit ns);
        for (int i = 0; i < NC; i++)
            if (sel[i] && lvl_ok(i, el, ns) && mval[i] == a) return 1;
        return 0;
    endfunction

    function automatic void model_wr(logic [5:0] wa, logic [63:0] wd);
        for (int i = 0; i < NC; i++) begin
            if (wa == 6'(i)) mval[i] = wd;
            if (wa == 6'(16 + i)) macc[i] = wd[15:8];
        end
        if (wa == 6'd32) begin mev = wd[0]; mstat = wd[9]; end
        if (wa == 6'd33) mincl = wd[NP-1:0];
        if (wa == 6'd34) begin mstart = wd[NC-1:0]; mstop = wd[16+NC-1:16]; end
    endfunction

    // One cycle: optional write and optional instruction, then check at negedge.
    task automatic step(bit dw, logic [5:0] wa, logic [63:0] wd,
                        bit di, logic [63:0] a, bit [1:0] el, bit ns, string req);
        bit e, nst;
        @(negedge clk);
        wr_en = dw; wr_addr = wa; wr_data = wd;
        instr_valid = di; instr_addr = a; instr_el = el; instr_ns = ns;
        e = exp_en(a, el, ns);
        nst = mstat;
        if (di) begin
            if (any_hit(mstop, a, el, ns)) nst = 0;
            else if (any_hit(mstart, a, el, ns)) nst = 1;
        end
        if (dw) model_wr(wa, wd);
        if (dw && wa == 6'd32) nst = wd[9];
        mstat = nst;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; instr_valid = 0;
        if (di) begin
            chk({req, " valid"}, 64'(trace_valid), 64'd1);
            chk({req, " en"}, 64'(trace_en), 64'(e && di));
        end
        chk({req, " status"}, 64'(ss_status), 64'(mstat));
    endtask

    task automatic wr(logic [5:0] wa, logic [63:0] wd);
        step(1, wa, wd, 0, '0, 0, 0, "R2");
    endtask

    task automatic ins(logic [63:0] a, bit [1:0] el, bit ns, string req);
        step(0, '0, '0, 1, a, el, ns, req);
    endtask

    task automatic clear_all();
        for (int i = 0; i < NC; i++) begin wr(6'(i), 0); wr(6'(16 + i), 0); end
        wr(6'd33, 0);
        wr(6'd34, 0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < NC; i++) begin mval[i] = 0; macc[i] = 0; end
        mev = 0; mincl = 0; mstart = 0; mstop = 0; mstat = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 trace_valid", 64'(trace_valid), 0);
        chk("R1 trace_en", 64'(trace_en), 0);
        chk("R1 ss_status", 64'(ss_status), 0);
        ins(64'h1234, 0, 1, "R1 event off after reset");

        // R4/R12: event on, started, no include, no points
        wr(6'd32, 64'h201);
        ins(64'hDEAD_0000, 1, 1, "R4 no include");
        ins(64'h0, 0, 0, "R12 state held");

        // R3: inclusive bounds of pair 0
        wr(6'd0, 64'h100); wr(6'd1, 64'h1FF); wr(6'd33, 64'h1);
        ins(64'hFF, 0, 1, "R3 below low");
        ins(64'h100, 0, 1, "R3 at low");
        ins(64'h1FF, 0, 1, "R3 at high");
        ins(64'h200, 0, 1, "R3 above high");
        // Full-span pair 1, unsigned top address
        wr(6'd2, 64'h0); wr(6'd3, '1); wr(6'd33, 64'h2);
        ins('1, 2, 1, "R3 all-ones address");
        wr(6'd33, 64'h0);
        wr(6'd33, 64'h4);
        ins(64'h150, 0, 1, "R4 unprogrammed pair excludes");

        // R11: non-secure EL0 excluded on pair 1 (even comparator 2)
        wr(6'd33, 64'h2); wr(6'd18, 64'h1000);
        ins(64'h77, 0, 1, "R11 ns el0 excluded");
        ins(64'h77, 1, 1, "R11 ns el1 allowed");
        ins(64'h77, 0, 0, "R11 secure el0 allowed");
        wr(6'd18, 64'h0800);
        ins(64'h77, 3, 0, "R11 secure el3 excluded");

        // R6: event off
        wr(6'd32, 64'h200);
        ins(64'h77, 1, 1, "R6 event off");

        // R8/R10: start on odd comparator 5, stop on comparator 6
        clear_all();
        wr(6'd32, 64'h001);
        wr(6'd5, 64'h40); wr(6'd6, 64'h80);
        wr(6'd34, (64'h1 << 5) | (64'h1 << 22));
        ins(64'h10, 0, 1, "R8 no hit stays stopped");
        ins(64'h40, 0, 1, "R10 start hit uses old state");
        ins(64'h44, 0, 1, "R8 started after start hit");
        ins(64'h80, 0, 1, "R10 stop hit uses old state");
        ins(64'h84, 0, 1, "R8 stopped after stop hit");

        // R9: start and stop on one instruction
        wr(6'd6, 64'h40);
        wr(6'd32, 64'h201);
        chk("R7 status written", 64'(ss_status), 1);
        ins(64'h40, 0, 1, "R9 stop wins");
        wr(6'd32, 64'h201);
        wr(6'd34, (64'h1 << 5));
        wr(6'd32, 64'h001);
        // R13: write and instruction on the same cycle
        step(1, 6'd32, 64'h001, 1, 64'h40, 0, 1, "R13 write beats start");
        step(1, 6'd32, 64'h201, 1, 64'h33, 0, 1, "R13 write sets status");
        wr(6'd32, 64'h000);
        chk("R7 status cleared", 64'(ss_status), 0);

        // Random mixes
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < NC; i++) begin
                wr(6'(i), 64'($urandom_range(0, 255)));
                wr(6'(16 + i), ($urandom_range(0, 3) == 0) ? 64'($urandom_range(0, 255)) << 8 : 64'h0);
            end
            wr(6'd33, 64'($urandom_range(0, 15)));
            wr(6'd34, ($urandom_range(0, 2) == 0) ? 64'h0 :
                      (64'($urandom_range(0, 255)) | (64'($urandom_range(0, 255)) << 16)));
            wr(6'd32, 64'($urandom_range(0, 1)) | (64'($urandom_range(0, 1)) << 9));
            for (int j = 0; j < 40; j++) begin
                if ($urandom_range(0, 9) == 0)
                    step(1, 6'd32, 64'h1 | (64'($urandom_range(0, 1)) << 9), 1,
                         64'($urandom_range(0, 255)), 2'($urandom_range(0, 3)),
                         1'($urandom_range(0, 1)), "R13 random");
                else
                    ins(($urandom_range(0, 15) == 0) ? {$urandom, $urandom} : 64'($urandom_range(0, 255)),
                        2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R5 random");
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule